// File: doc/BRIEF.md
# Angle Sensor Register Access Port

This block is an SPI slave in mode 1 (clock idles low, data sampled on the trailing edge). It lets a host read and write the register space of an angle sensor. Every transfer is a 16-bit word framed by the active-low select. The first word of an access is a command. It carries an even-parity bit, a read/write flag and a 14-bit address. A write command is followed by a second word that carries the new register value. The select line, serial clock and data input are sampled by the system clock through two-stage synchronisers. The system clock must therefore run at least four times as fast as the serial clock.

Accesses are pipelined. The answer to a word appears on the data output during the next word. A read therefore returns its data one frame later. During the data word of a write, the old content of the target register comes back, and the frame after that returns the new content. Each answer carries its own even parity and an error-echo bit. The error-echo bit reports whether the previous frame failed. Framing, parity and address faults set bits in a sticky error register, and a read of that register clears it.

Angle, magnitude and diagnostic values come in on input ports and can be read but not written. A small bank of configuration registers can be both read and written.

Top module: `angle_spi_slave`

## Requirements
- R1: Data input bits are taken on falling serial-clock edges while select is low, MSB first. The data output presents answer bit 15 once select falls and moves to the next lower bit after each falling edge.
- R2: A command word has even parity in bit 15 over bits 14:0, read (1) or write (0) in bit 14, and the address in bits 13:0. The bits of a word are checked and acted on when select rises.
- R3: Each answer word is {P, E, D}: D (bits 13:0) is the data, E (bit 14) is the error echo, and P (bit 15) makes the whole word have even parity. The answer to a read command is sent during the next frame.
- R4: A write command to a writable address makes the next word a data word. The answer during that data word is the register's old content. A correct data word stores its bits 13:0, and the frame after it returns the new value.
- R5: The error register at 0x0001 holds bit 2 for parity, bit 1 for invalid command and bit 0 for framing. Its bits stay set until a read of 0x0001, which returns the content and then clears it to zero.
- R6: A frame whose falling-edge count is not 16 sets error bit 0 and is not executed. Its answer is data 0 with E=1.
- R7: A word with odd parity sets error bit 2 and is not executed. This applies to both command and data words, and a data word with bad parity leaves the target register unchanged. Its answer is data 0 with E=1.
- R8: A read of an unmapped address, or a write to an address that is not writable, sets error bit 1. Its answer is data 0 with E=1.
- R9: E is 1 exactly when the frame before the current one failed, for any of the reasons in R6 to R8. A successful access answers with E=0.
- R10: The read-only map is as follows. 0x0000 reads 0. 0x3FFC returns the diagnostic input and 0x3FFD the magnitude input. 0x3FFE returns the uncompensated angle. 0x3FFF returns the compensated angle, or the uncompensated angle when bit 6 of 0x0018 is 1.
- R11: The writable registers are 0x0003 and 0x0016 to 0x0019. Each holds 14 bits. After reset 0x0018 reads 0x0001 and the others read 0.
- R12: The output enable is low in reset and whenever select is high, and high while select is low. The first answer after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from host |
| angle_raw | input | 14 | Uncompensated angle |
| angle_comp | input | 14 | Compensated angle |
| magnitude | input | 14 | Vector magnitude |
| diag | input | 14 | Diagnostic and gain word |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso |

## Verification
The main function is tried with a stream of back-to-back read commands over every read-only address, each fed by distinct input values. This separates the one-frame answer delay from an immediate answer, and it catches a swapped address decode. Write pairs follow and are read back, including one write that sets the angle-select bit. These show that the old value is returned during the data word and that the selection moves 0x3FFF from the compensated angle to the uncompensated one. Fault patterns come next: a command with bad parity, short and long frames, a write to a read-only address, an unmapped read and a data word with bad parity. Each is followed by reads of the error register, which tell apart the three error bits, the E echo and the clear on read.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADR_NOP  = 'h0000;
  localparam int ADR_ERR  = 'h0001;
  localparam int ADR_PROG = 'h0003;
  localparam int ADR_ZHI  = 'h0016;
  localparam int ADR_ZLO  = 'h0017;
  localparam int ADR_CFG1 = 'h0018;
  localparam int ADR_CFG2 = 'h0019;
  localparam int ADR_DIAG = 'h3FFC;
  localparam int ADR_MAG  = 'h3FFD;
  localparam int ADR_RAW  = 'h3FFE;
  localparam int ADR_ANG  = 'h3FFF;

  localparam int EB_FRM = 0;
  localparam int EB_INV = 1;
  localparam int EB_PAR = 2;
  localparam int EB_W   = 3;

  localparam int CFG1_RAWSEL = 6;

  typedef enum logic {PH_CMD, PH_DATA} phase_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[CW-W-1:0], d};
  end

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/spi_frame_phy.sv
module spi_frame_phy #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_s,
  input  logic               sclk_s,
  input  logic               mosi_s,
  input  logic [FRAME_W-1:0] resp_word,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame_word,
  output logic               frame_len_ok,
  output logic               miso,
  output logic               miso_oe
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic cs_q, sclk_q;
  logic [FRAME_W-1:0] rx_sh, tx_sh;
  logic [CNT_W-1:0] edge_cnt;
  logic cs_fall, cs_rise, sclk_fall;

  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_fall = sclk_q & ~sclk_s & ~cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1; sclk_q <= 1'b0;
      rx_sh <= '0; tx_sh <= '0; edge_cnt <= '0;
      frame_done <= 1'b0; frame_word <= '0; frame_len_ok <= 1'b0;
      miso <= 1'b0; miso_oe <= 1'b0;
    end else begin
      cs_q       <= cs_s;
      sclk_q     <= sclk_s;
      frame_done <= cs_rise;
      miso_oe    <= ~cs_s;
      miso       <= cs_s ? 1'b0 : tx_sh[FRAME_W-1];
      if (cs_fall) begin
        edge_cnt <= '0;
        rx_sh    <= '0;
        tx_sh    <= resp_word;
      end else if (sclk_fall) begin
        rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
      end
      if (cs_rise) begin
        frame_word   <= rx_sh;
        frame_len_ok <= (edge_cnt == CNT_W'(FRAME_W));
      end
    end
  end

  // R3
  resp_parity_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (^tx_sh) == 1'b0);

  // R12
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !miso_oe);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mapped,
  output logic              rd_writable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [EB_W-1:0]   err_flags,
  input  logic [DATA_W-1:0] angle_raw,
  input  logic [DATA_W-1:0] angle_comp,
  input  logic [DATA_W-1:0] magnitude,
  input  logic [DATA_W-1:0] diag
);
  localparam int NW = 5;
  localparam int CFG1_IDX = 3;
  localparam int WADR [NW] = '{ADR_PROG, ADR_ZHI, ADR_ZLO, ADR_CFG1, ADR_CFG2};
  localparam int WRST [NW] = '{0, 0, 0, 1, 0};

  logic [DATA_W-1:0] wreg [NW];
  logic [NW-1:0] rhit, whit;

  for (genvar i = 0; i < NW; i++) begin : g_dec
    assign rhit[i] = (rd_addr == DATA_W'(WADR[i]));
    assign whit[i] = (wr_addr == DATA_W'(WADR[i]));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (rst) wreg[i] <= DATA_W'(WRST[i]);
      else if (wr_en && whit[i]) wreg[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_mapped = 1'b0;
    rd_writable = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (rhit[i]) begin
        rd_data = wreg[i];
        rd_mapped = 1'b1;
        rd_writable = 1'b1;
      end
    end
    if (rd_addr == DATA_W'(ADR_NOP)) begin
      rd_mapped = 1'b1;
    end else if (rd_addr == DATA_W'(ADR_ERR)) begin
      rd_data = {{(DATA_W-EB_W){1'b0}}, err_flags};
      rd_mapped = 1'b1;
    end else if (rd_addr == DATA_W'(ADR_DIAG)) begin
      rd_data = diag; rd_mapped = 1'b1;
    end else if (rd_addr == DATA_W'(ADR_MAG)) begin
      rd_data = magnitude; rd_mapped = 1'b1;
    end else if (rd_addr == DATA_W'(ADR_RAW)) begin
      rd_data = angle_raw; rd_mapped = 1'b1;
    end else if (rd_addr == DATA_W'(ADR_ANG)) begin
      rd_data = wreg[CFG1_IDX][CFG1_RAWSEL] ? angle_raw : angle_comp;
      rd_mapped = 1'b1;
    end
  end

  // R11
  wr_target_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (|whit));
endmodule

// File: rtl/angle_spi_slave.sv
module angle_spi_slave
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [DATA_W-1:0] angle_raw,
  input  logic [DATA_W-1:0] angle_comp,
  input  logic [DATA_W-1:0] magnitude,
  input  logic [DATA_W-1:0] diag,
  output logic              miso,
  output logic              miso_oe
);
  localparam int FRAME_W = DATA_W + 2;

  logic cs_s, sclk_s, mosi_s;
  logic frame_done, frame_len_ok;
  logic [FRAME_W-1:0] frame_word, resp_word;
  logic [DATA_W-1:0] rd_data, pend_addr, resp_data, cmd_addr;
  logic rd_mapped, rd_writable, wr_en, par_ok, is_rd, resp_ef;
  logic [EB_W-1:0] err_flags;
  phase_t phase;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, mosi}), .q({cs_s, sclk_s, mosi_s}));

  spi_frame_phy #(.FRAME_W(FRAME_W)) u_phy (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .resp_word(resp_word), .frame_done(frame_done), .frame_word(frame_word),
    .frame_len_ok(frame_len_ok), .miso(miso), .miso_oe(miso_oe));

  assign cmd_addr = frame_word[DATA_W-1:0];
  assign is_rd    = frame_word[FRAME_W-2];
  assign par_ok   = ~^frame_word;
  assign wr_en    = frame_done & frame_len_ok & par_ok & (phase == PH_DATA);
  assign resp_word = {^{resp_ef, resp_data}, resp_ef, resp_data};

  spi_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .rd_addr(cmd_addr), .rd_data(rd_data),
    .rd_mapped(rd_mapped), .rd_writable(rd_writable), .wr_en(wr_en),
    .wr_addr(pend_addr), .wr_data(cmd_addr), .err_flags(err_flags),
    .angle_raw(angle_raw), .angle_comp(angle_comp), .magnitude(magnitude),
    .diag(diag));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CMD; pend_addr <= '0; err_flags <= '0;
      resp_data <= '0; resp_ef <= 1'b0;
    end else if (frame_done) begin
      phase <= PH_CMD;
      resp_data <= '0;
      resp_ef <= 1'b1;
      if (!frame_len_ok) begin
        err_flags[EB_FRM] <= 1'b1;
      end else if (!par_ok) begin
        err_flags[EB_PAR] <= 1'b1;
      end else if (phase == PH_DATA) begin
        resp_data <= cmd_addr;
        resp_ef <= 1'b0;
      end else if (is_rd && rd_mapped) begin
        resp_data <= rd_data;
        resp_ef <= 1'b0;
        if (cmd_addr == DATA_W'(ADR_ERR)) err_flags <= '0;
      end else if (!is_rd && rd_writable) begin
        resp_data <= rd_data;
        resp_ef <= 1'b0;
        phase <= PH_DATA;
        pend_addr <= cmd_addr;
      end else begin
        err_flags[EB_INV] <= 1'b1;
      end
    end
  end

  // R5
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_len_ok && par_ok && phase == PH_CMD && is_rd
     && cmd_addr == DATA_W'(ADR_ERR)) |=> err_flags == '0);

  // R6
  frame_err_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_len_ok) |=> (err_flags[EB_FRM] && resp_ef));

  // R7
  parity_err_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_len_ok && !par_ok) |=> (err_flags[EB_PAR] && resp_ef && !wr_en));

  // R4
  data_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phase == PH_DATA) |-> $past(frame_done));
endmodule

// File: tb/tb_angle_spi_slave.sv
module tb_angle_spi_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [13:0] angle_raw  = 14'h1234;
  logic [13:0] angle_comp = 14'h0ABC;
  logic [13:0] magnitude  = 14'h0555;
  logic [13:0] diag       = 14'h0180;
  logic miso, miso_oe;
  int n_chk = 0, n_fail = 0;
  logic oe_seen;
  logic [15:0] got;

  always #10 clk = ~clk;

  angle_spi_slave dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .angle_raw(angle_raw), .angle_comp(angle_comp), .magnitude(magnitude),
    .diag(diag), .miso(miso), .miso_oe(miso_oe));

  typedef struct packed {
    logic [14:0] raw;
    logic [14:0] exp;
  } vec_t;

  // raw: bit 14 = read flag or data-word zero, bits 13:0 address/data
  // exp: bit 14 = error echo, bits 13:0 data of the answer
  localparam vec_t VEC [21] = '{
    '{15'h7FFF, 15'h0000},  // R12 first answer zero
    '{15'h7FFE, 15'h0ABC},  // R10 0x3FFF compensated
    '{15'h7FFD, 15'h1234},  // R10 0x3FFE raw
    '{15'h7FFC, 15'h0555},  // R10 magnitude
    '{15'h4018, 15'h0180},  // R10 diag
    '{15'h4000, 15'h0001},  // R11 cfg1 reset
    '{15'h0018, 15'h0000},  // write cmd, answer of NOP read
    '{15'h0041, 15'h0001},  // R4 old content
    '{15'h7FFF, 15'h0041},  // R4 new content
    '{15'h4019, 15'h1234},  // R10 selection bit moves to raw
    '{15'h0016, 15'h0000},  // R11 cfg2 reset
    '{15'h00AB, 15'h0000},  // R4 old zero-hi
    '{15'h4016, 15'h00AB},  // R4 new
    '{15'h4017, 15'h00AB},  // R3 read pipelined
    '{15'h4001, 15'h0000},  // R11 zero-lo reset
    '{15'h3FFE, 15'h0000},  // R5 err reads 0
    '{15'h4001, 15'h4000},  // R8 R9 write to read-only
    '{15'h4000, 15'h0002},  // R5 invalid bit
    '{15'h4005, 15'h0000},  // R5 cleared
    '{15'h4001, 15'h4000},  // R8 unmapped read
    '{15'h4000, 15'h0002}   // R8 R5 invalid bit again
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [14:0] e);
    return {^e, e};
  endfunction

  task automatic xfer(input logic [14:0] raw, input logic flip, input int nbits,
                      output logic [15:0] rx);
    logic [15:0] w;
    w = {(^raw) ^ flip, raw};
    rx = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 16) rx[15-i] = miso;
      if (i == 8) oe_seen = miso_oe;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 oe after reset", {15'b0, miso_oe}, 16'h0000);
    check("R12 miso after reset", {15'b0, miso}, 16'h0000);

    // R1 R2 R3 table walk
    foreach (VEC[k]) begin
      xfer(VEC[k].raw, 1'b0, 16, got);
      check($sformatf("R1/R3 vector %0d", k), got, mk(VEC[k].exp));
    end
    check("R12 oe during frame", {15'b0, oe_seen}, 16'h0001);
    check("R12 oe after frame", {15'b0, miso_oe}, 16'h0000);

    // R7 command parity error
    xfer(15'h7FFE, 1'b1, 16, got); check("R7 bad-parity frame answer", got, mk(15'h0000));
    xfer(15'h4000, 1'b0, 16, got); check("R7 R9 echo after parity", got, mk(15'h4000));
    xfer(15'h4001, 1'b0, 16, got); check("R9 echo clears", got, mk(15'h0000));
    xfer(15'h4000, 1'b0, 16, got); check("R5 R7 parity bit", got, mk(15'h0004));

    // R6 short and long frames
    xfer(15'h4001, 1'b0, 12, got);
    xfer(15'h4001, 1'b0, 16, got); check("R6 R9 short frame echo", got, mk(15'h4000));
    xfer(15'h4000, 1'b0, 16, got); check("R6 framing bit short", got, mk(15'h0001));
    xfer(15'h4000, 1'b0, 17, got);
    xfer(15'h4001, 1'b0, 16, got); check("R6 long frame echo", got, mk(15'h4000));
    xfer(15'h4000, 1'b0, 16, got); check("R6 framing bit long", got, mk(15'h0001));

    // R7 data word with bad parity does not write
    xfer(15'h0017, 1'b0, 16, got); check("R4 write cmd answer", got, mk(15'h0000));
    xfer(15'h0015, 1'b1, 16, got); check("R4 old content zero-lo", got, mk(15'h0000));
    xfer(15'h4017, 1'b0, 16, got); check("R7 bad data echo", got, mk(15'h4000));
    xfer(15'h4001, 1'b0, 16, got); check("R7 zero-lo unchanged", got, mk(15'h0000));
    xfer(15'h4000, 1'b0, 16, got); check("R7 parity bit data", got, mk(15'h0004));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule